// File: doc/BRIEF.md
# Clock Power-Down Gating Sequencer

This block sits between the free-running clock sources of a multi-output clock generator and its output pins. It controls how those outputs shut down and start up again. An asynchronous, active-low power-down request is first brought into the internal reference-clock domain. The sequencer then withdraws a run permission from every output group. Each group parks its output low on its own next falling edge. Only after every group has confirmed that it is parked does the sequencer drop the oscillator and VCO enables.

When the request is released, the oscillator and VCOs are enabled again. The block waits a parameterized lock interval before the groups may switch again. That interval is chosen so that the first valid clocks appear well within 3 ms. A per-group enable bit holds a group low without glitches at any time, and a global high-impedance control turns off the output drivers.

Clock synthesis and spread-spectrum modulation are outside this block. The sources arrive as plain input clocks.

Top module: `clk_pd_seq`

## Requirements
- R1: `pd_ni` passes through two flops clocked by `clk_i` before it acts, so the oscillator enable stays high for at least three `clk_i` edges after `pd_ni` falls.
- R2: Once the run permission is withdrawn, each output stops low on a falling edge of its own source, and no high phase is ever cut short.
- R3: `osc_en_o` and `vco_en_o` fall together, only in a cycle where every output is already low, and they stay low for the whole power-down.
- R4: Power-down waits for the slowest group: the enables drop only after all groups, including disabled ones, report parked, and after a minimum park dwell of `PARK_MIN` cycles.
- R5: A group whose `grp_en_i` bit is 0 holds its output low and does not switch. Setting the bit to 1 resumes switching. Changing the bit never produces a high or low pulse shorter than half a source period.
- R6: After `pd_ni` rises, the enables return exactly three `clk_i` edges later. The outputs then stay low for at least `LOCK_CYC` cycles before they resume switching.
- R7: A new power-down request during the lock wait returns the sequencer to parking, and the enables drop again without any output having switched.
- R8: `hiz_i` = 1 drives `drive_en_o` to 0 (outputs high impedance), whatever the sequencer state; `hiz_i` = 0 gives `drive_en_o` = 1.
- R9: After reset, the sequencer is running with both enables high and all outputs low, and every enabled group begins switching on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal fast reference clock for the sequencer |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to clk_i |
| pd_ni | input | 1 | Asynchronous power-down request, active low |
| hiz_i | input | 1 | Global high-impedance control, 1 = outputs not driven |
| grp_src_i | input | NUM_GRP | Free-running source clock of each output group |
| grp_en_i | input | NUM_GRP | Per-group enable, 0 = held low |
| grp_clk_o | output | NUM_GRP | Gated clock of each output group |
| drive_en_o | output | 1 | Output driver enable, 0 = high impedance |
| osc_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | VCO enable |

## Verification
The hardest situation to create is a new power-down request that lands inside the lock wait, while every output is still parked but the enables have just returned. The bench gets there by watching `osc_en_o` rise after a release and then pulling `pd_ni` low again after a random number of cycles that is shorter than the lock interval. The stimulus also uses source clocks whose periods differ by a factor of seven, so that the slowest group sets the park latency. Randomly changing the per-group enables while the outputs run exercises the glitch-free gate edges, and a pulse-width monitor measures every output pulse against its source's half period.

// File: rtl/clk_pd_pkg.sv
package clk_pd_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PARK = 2'd1,
    ST_OFF  = 2'd2,
    ST_WAKE = 2'd3
  } pd_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int unsigned W       = 1,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o,
  output logic busy_o
);

  logic req_q;
  logic gate_q;

  // Both stages move on the falling edge, while the source is low, so the
  // gate never opens or closes inside a high phase.
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      req_q  <= en_i;
      gate_q <= req_q;
    end
  end

  assign clk_o  = src_clk_i & gate_q;
  // Busy while a permission is still in flight or the gate is open.
  assign busy_o = req_q | gate_q;

endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import clk_pd_pkg::*;
#(
  parameter int unsigned LOCK_CYC = 512,
  parameter int unsigned PARK_MIN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_req_i,
  input  logic all_idle_i,
  output logic allow_o,
  output logic osc_en_o,
  output logic vco_en_o
);

  localparam int unsigned CNT_MAX = max_u(LOCK_CYC, PARK_MIN);
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYC - 1);
  localparam logic [CW-1:0] PARK_LAST = CW'(PARK_MIN - 1);
  localparam logic [CW-1:0] CNT_TOP   = CW'(CNT_MAX);

  pd_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          allow_q, pwr_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        cnt_d  = '0;
        cnt_en = 1'b1;
        if (pd_req_i) state_d = ST_PARK;
      end
      ST_PARK: begin
        cnt_en = 1'b1;
        if (all_idle_i && (cnt_q >= PARK_LAST)) begin
          state_d = ST_OFF;
          cnt_d   = '0;
        end else if (cnt_q != CNT_TOP) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_OFF: begin
        cnt_d  = '0;
        cnt_en = 1'b1;
        if (!pd_req_i) state_d = ST_WAKE;
      end
      ST_WAKE: begin
        cnt_en = 1'b1;
        if (pd_req_i) begin
          state_d = ST_PARK;
          cnt_d   = '0;
        end else if (cnt_q == LOCK_LAST) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_PARK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      allow_q <= 1'b1;
      pwr_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      allow_q <= (state_d == ST_RUN);
      pwr_q   <= (state_d != ST_OFF);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign allow_o  = allow_q;
  assign osc_en_o = pwr_q;
  assign vco_en_o = pwr_q;

  p_req_to_park_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && pd_req_i) |=> (state_q == ST_PARK));

  p_off_idle_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF) |-> all_idle_i);

  p_lock_wait_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_WAKE && state_q == ST_RUN) |-> ($past(cnt_q) == LOCK_LAST));

  p_wake_abort_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE && pd_req_i) |=> (state_q == ST_PARK));

endmodule

// File: rtl/clk_pd_seq.sv
module clk_pd_seq #(
  parameter int unsigned NUM_GRP  = 4,
  parameter int unsigned LOCK_CYC = 512,
  parameter int unsigned PARK_MIN = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pd_ni,
  input  logic               hiz_i,
  input  logic [NUM_GRP-1:0] grp_src_i,
  input  logic [NUM_GRP-1:0] grp_en_i,
  output logic [NUM_GRP-1:0] grp_clk_o,
  output logic               drive_en_o,
  output logic               osc_en_o,
  output logic               vco_en_o
);

  logic               pd_sync;
  logic               pd_req;
  logic               allow;
  logic [NUM_GRP-1:0] busy;
  logic [NUM_GRP-1:0] busy_sync;
  logic               all_idle;

  cdc_sync #(.W(1), .RST_VAL(1'b1)) u_pd_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pd_ni),
    .q_o    (pd_sync)
  );

  assign pd_req = ~pd_sync;

  for (genvar g = 0; g < NUM_GRP; g++) begin : gen_grp
    clk_gate_cell u_gate (
      .src_clk_i (grp_src_i[g]),
      .rst_ni    (rst_ni),
      .en_i      (grp_en_i[g] & allow),
      .clk_o     (grp_clk_o[g]),
      .busy_o    (busy[g])
    );
  end

  cdc_sync #(.W(NUM_GRP), .RST_VAL(1'b0)) u_busy_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (busy),
    .q_o    (busy_sync)
  );

  assign all_idle = (busy_sync == '0);

  pd_seq_fsm #(.LOCK_CYC(LOCK_CYC), .PARK_MIN(PARK_MIN)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_req_i   (pd_req),
    .all_idle_i (all_idle),
    .allow_o    (allow),
    .osc_en_o   (osc_en_o),
    .vco_en_o   (vco_en_o)
  );

  assign drive_en_o = ~hiz_i;

  p_sync_lat_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_req) |-> !$past(pd_ni, 2));

  p_osc_off_parked_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> (grp_clk_o == '0));

  p_off_no_switch_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && $past(!osc_en_o)) |-> (grp_clk_o == '0));

endmodule

// File: tb/tb_clk_pd_seq.sv
`timescale 1ns/1ps
module tb_clk_pd_seq;

  localparam int NG  = 4;
  localparam int LCK = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pd_n;
  logic          hiz;
  logic [NG-1:0] src = '0;
  logic [NG-1:0] en;
  logic [NG-1:0] gclk;
  logic          drv, osc, vco;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;
  always #5  src[0] = ~src[0];
  always #7  src[1] = ~src[1];
  always #12 src[2] = ~src[2];
  always #35 src[3] = ~src[3];

  clk_pd_seq #(.NUM_GRP(NG), .LOCK_CYC(LCK), .PARK_MIN(3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pd_ni(pd_n), .hiz_i(hiz),
    .grp_src_i(src), .grp_en_i(en), .grp_clk_o(gclk),
    .drive_en_o(drv), .osc_en_o(osc), .vco_en_o(vco)
  );

  function automatic real half_ns(input int g);
    case (g)
      0: return 5.0;
      1: return 7.0;
      2: return 12.0;
      default: return 35.0;
    endcase
  endfunction

  function automatic logic [NG-1:0] exp_switching(input logic [NG-1:0] e, input bit running);
    return running ? e : '0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pulse-width monitor and rise counters (R2, R5)
  int rises_w [NG];
  for (genvar g = 0; g < NG; g++) begin : gen_mon
    int  rises = 0;
    real t_r = -1.0;
    real t_f = -1.0;
    always @(posedge gclk[g]) begin
      rises++;
      if (t_f >= 0.0)
        check(($realtime - t_f) > half_ns(g) - 0.01, "R5", "low phase too short",
              longint'(($realtime - t_f) * 1000), longint'(half_ns(g) * 1000));
      t_r = $realtime;
    end
    always @(negedge gclk[g]) begin
      if (t_r >= 0.0)
        check((($realtime - t_r) - half_ns(g)) < 0.01 && (half_ns(g) - ($realtime - t_r)) < 0.01,
              "R2", "high phase width", longint'(($realtime - t_r) * 1000),
              longint'(half_ns(g) * 1000));
      t_f = $realtime;
    end
    assign rises_w[g] = rises;
  end

  function automatic int total_rises();
    int s = 0;
    for (int g = 0; g < NG; g++) s += rises_w[g];
    return s;
  endfunction

  task automatic observe(input int cyc, output logic [NG-1:0] seen);
    int base [NG];
    for (int g = 0; g < NG; g++) base[g] = rises_w[g];
    repeat (cyc) @(negedge clk);
    for (int g = 0; g < NG; g++) seen[g] = (rises_w[g] != base[g]);
  endtask

  task automatic wait_osc(input logic val, input int maxc, output int n);
    n = 0;
    while (osc !== val && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic power_down(input string req);
    int n;
    pd_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(osc === 1'b1, "R1", "osc enable held during sync", osc, 1);
    end
    wait_osc(1'b0, 200, n);
    check(n < 200, req, "parked within bound", n, 199);
    check(gclk === '0 && vco === 1'b0, "R3", "outputs low when enables drop", gclk, 0);
  endtask

  task automatic hold_off(input int cyc);
    bit bad = 1'b0;
    int r0 = total_rises();
    repeat (cyc) begin
      @(negedge clk);
      if (osc !== 1'b0 || vco !== 1'b0 || gclk !== '0) bad = 1'b1;
    end
    check(!bad && total_rises() == r0, "R4", "all outputs held low in power-down",
          total_rises() - r0, 0);
  endtask

  task automatic release_and_resume(input bit expect_resume);
    int n, c, r0;
    pd_n = 1'b1;
    wait_osc(1'b1, 10, n);
    check(n == 3, "R6", "enable return latency", n, 3);
    r0 = total_rises();
    c = 0;
    while (total_rises() == r0 && c < LCK + 60) begin
      @(negedge clk);
      c++;
    end
    if (expect_resume)
      check(c >= LCK - 1 && c <= LCK + 40, "R6", "cycles until first output edge", c, LCK);
    else
      check(total_rises() == r0, "R5", "disabled groups stay low after wake",
            total_rises() - r0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NG-1:0] seen;
    int n;
    void'($urandom(32'd1234));
    rst_n = 1'b0; pd_n = 1'b1; hiz = 1'b0; en = '1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(osc === 1'b1 && vco === 1'b1, "R9", "enables high after reset", {osc, vco}, 3);
    check(gclk === '0, "R9", "outputs low right after reset", gclk, 0);
    check(drv === 1'b1, "R8", "driven after reset", drv, 1);
    repeat (60) @(negedge clk);
    observe(40, seen);
    check(seen == exp_switching('1, 1'b1), "R9", "all groups switching", seen, '1);

    for (int it = 0; it < 12; it++) begin
      logic [NG-1:0] e;
      e = NG'($urandom) | NG'(1);
      if (it == 3) e = '1;
      en = e;
      repeat (60) @(negedge clk);
      observe(40, seen);
      check(seen == exp_switching(e, 1'b1), "R5", "switching follows enables", seen, e);

      hiz = 1'($urandom);
      #1;
      check(drv === ~hiz, "R8", "driver enable follows hiz", drv, ~hiz);
      hiz = 1'b0;
      @(negedge clk);

      power_down("R4");
      hold_off(5 + int'($urandom % 36));

      if (it % 2 == 1) begin
        int r0;
        pd_n = 1'b1;
        wait_osc(1'b1, 10, n);
        r0 = total_rises();
        repeat (1 + int'($urandom % (LCK - 10))) @(negedge clk);
        pd_n = 1'b0;
        wait_osc(1'b0, 12, n);
        check(n < 12, "R7", "re-request during lock wait parks again", n, 11);
        check(total_rises() == r0, "R7", "no output edge during aborted wake",
              total_rises() - r0, 0);
        hold_off(5);
      end
      release_and_resume(1'b1);
    end

    // Directed: every group disabled, power-down still completes
    en = '0;
    repeat (60) @(negedge clk);
    pd_n = 1'b0;
    wait_osc(1'b0, 12, n);
    check(n < 12, "R4", "park with all groups disabled", n, 11);
    hold_off(10);
    release_and_resume(1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule